// File: doc/BRIEF.md
# Vector Color Pack-and-Insert Unit

This unit turns a 128-bit vector of four 32-bit lanes into a single 32-bit ARGB color word. Each lane holds a float that is biased to sit near 3.0, so the channel value is carried in the low mantissa byte. The unit clamps each lane to that window and keeps the byte. It then writes the packed word, and for some masks a zero word, into a copy of the old destination vector. The 2-bit shift field picks the word position and the 2-bit mask field picks how many words are written.

A caller gives the source and old destination vectors together with the type, mask and shift fields, and pulses `in_valid_i`. One cycle later the new destination vector appears on `dst_o`, marked by a one-cycle `out_valid_o`. Only the color pack type is built. Any other type code sets an unsupported flag and returns the destination unchanged. A zero mask sets an error flag and also returns the destination unchanged.

Top module: `color_pack_insert`

## Requirements
- R1: Type code 0 selects the color pack. Any nonzero type code (for example 1, 3 or 5) sets `unsupported_o` with the result, and `dst_o` equals the old destination.
- R2: Each lane is compared as a signed 32-bit integer with the window 0x40400000..0x404000FF. Below the window the channel is 0x00 (this covers negative floats and small integers). Above it the channel is 0xFF (this covers NaN and infinity). Inside the window the channel is the low 8 bits.
- R3: Lanes are numbered 0..3 from bits 127:96 downward. The packed word is {lane3, lane0, lane1, lane2} from bit 31 down. Lanes ending in 1, 2, 3 and 4 give 0x04010203.
- R4: Destination words are numbered 0..3 from bits 127:96 downward. The packed word goes to word 3 minus shift.
- R5: Mask 1 writes only the packed word. Every other destination word keeps its old value.
- R6: Mask 2 also writes 0x00000000 into the word just left of the packed word. When that word would be left of word 0, the zero is dropped.
- R7: Mask 3 acts like mask 2 for shifts 0..2. Mask 3 with shift 3 writes only 0x00000000 into word 3 and leaves words 0..2 unchanged.
- R8: Mask 0 sets `mask_err_o` with the result, and `dst_o` equals the old destination.
- R9: `out_valid_o` is high for exactly the cycle after each `in_valid_i` cycle. The flags are high only together with `out_valid_o`. `dst_o` holds its value while no request arrives. Reset clears `out_valid_o`, both flags and `dst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| src_i | input | 128 | Source lanes |
| dst_i | input | 128 | Old destination vector |
| type_i | input | 3 | Pack type code |
| mask_i | input | 2 | Insert mask code |
| shift_i | input | 2 | Insert word shift |
| out_valid_o | output | 1 | Result strobe, one cycle |
| dst_o | output | 128 | New destination vector |
| unsupported_o | output | 1 | Nonzero type code seen |
| mask_err_o | output | 1 | Zero mask seen |

## Verification
The assertions assume that the type, mask, shift and both vectors are stable and meaningful only in cycles where `in_valid_i` is high, and they compare the result with the inputs one cycle earlier. The bench drives every input on the falling edge and holds it for a full cycle. It drops `in_valid_i` between requests, so the pass-through and hold properties each see exactly one request. It sweeps all type, mask and shift codes against fixed lane patterns. The lane values straddle both ends of the clamp window, including negative, NaN and infinity encodings.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  localparam int unsigned VEC_W  = 128;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned CH_W   = 8;
  localparam int unsigned LANES  = VEC_W / LANE_W;

  typedef enum logic [2:0] {
    PK_COLOR  = 3'd0,
    PK_SHORT2 = 3'd1,
    PK_HALF2  = 3'd3,
    PK_HALF4  = 3'd5
  } pack_kind_e;

  typedef enum logic [1:0] {
    MK_NONE = 2'd0,
    MK_ONE  = 2'd1,
    MK_TWO  = 2'd2,
    MK_ALT  = 2'd3
  } mask_kind_e;
endpackage

// File: rtl/cpi_lane_clamp.sv
module cpi_lane_clamp #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned CH_W   = 8,
  parameter logic [LANE_W-1:0] LO_BOUND = 32'h4040_0000
) (
  input  logic [LANE_W-1:0] lane_i,
  output logic [CH_W-1:0]   chan_o
);
  localparam logic [LANE_W-1:0] HI_BOUND = LO_BOUND + LANE_W'((1 << CH_W) - 1);

  logic below, above;
  logic [LANE_W-1:0] offset;

  always_comb begin
    below  = $signed(lane_i) < $signed(LO_BOUND);
    above  = $signed(lane_i) > $signed(HI_BOUND);
    offset = lane_i - LO_BOUND;
    if (below)      chan_o = '0;
    else if (above) chan_o = '1;
    else            chan_o = offset[CH_W-1:0];
  end
endmodule

// File: rtl/cpi_color_pack.sv
module cpi_color_pack #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32,
  parameter int unsigned CH_W   = 8
) (
  input  logic [LANES*LANE_W-1:0] src_i,
  output logic [LANES*CH_W-1:0]   word_o
);
  logic [CH_W-1:0] chan [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cpi_lane_clamp #(
      .LANE_W(LANE_W),
      .CH_W  (CH_W)
    ) i_clamp (
      .lane_i(src_i[(LANES-1-l)*LANE_W +: LANE_W]),
      .chan_o(chan[l])
    );
  end

  // slot k (from msb) carries lane (k-1) mod LANES: last lane leads
  for (genvar k = 0; k < LANES; k++) begin : g_slot
    assign word_o[(LANES-1-k)*CH_W +: CH_W] = chan[(k+LANES-1) % LANES];
  end
endmodule

// File: rtl/cpi_word_insert.sv
module cpi_word_insert #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned SH_W  = $clog2(WORDS)
) (
  input  logic [WORDS*WORD_W-1:0] dst_i,
  input  logic [WORD_W-1:0]       word_i,
  input  logic [1:0]              mask_i,
  input  logic [SH_W-1:0]         shift_i,
  output logic [WORDS*WORD_W-1:0] dst_o
);
  logic special;
  int   pos;

  always_comb begin
    special = (mask_i == 2'd3) && (shift_i == SH_W'(WORDS-1));
    pos     = int'(WORDS-1) - int'(shift_i);
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_comb begin
      dst_o[(WORDS-1-w)*WORD_W +: WORD_W] = dst_i[(WORDS-1-w)*WORD_W +: WORD_W];
      if (special) begin
        if (w == WORDS-1) dst_o[(WORDS-1-w)*WORD_W +: WORD_W] = '0;
      end else if (mask_i != 2'd0) begin
        if (w == pos)
          dst_o[(WORDS-1-w)*WORD_W +: WORD_W] = word_i;
        else if (mask_i[1] && (w == pos - 1))
          dst_o[(WORDS-1-w)*WORD_W +: WORD_W] = '0;
      end
    end
  end
endmodule

// File: rtl/color_pack_insert.sv
module color_pack_insert
  import cpi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [2:0]       type_i,
  input  logic [1:0]       mask_i,
  input  logic [1:0]       shift_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] dst_o,
  output logic             unsupported_o,
  output logic             mask_err_o
);
  localparam int unsigned WORD_W = LANES * CH_W;
  localparam int unsigned WORDS  = VEC_W / WORD_W;

  logic [WORD_W-1:0] packed_word;
  logic [VEC_W-1:0]  merged;
  logic              bad_type, bad_mask;

  cpi_color_pack #(
    .LANES (LANES),
    .LANE_W(LANE_W),
    .CH_W  (CH_W)
  ) i_pack (
    .src_i (src_i),
    .word_o(packed_word)
  );

  cpi_word_insert #(
    .WORDS (WORDS),
    .WORD_W(WORD_W)
  ) i_insert (
    .dst_i  (dst_i),
    .word_i (packed_word),
    .mask_i (mask_i),
    .shift_i(shift_i),
    .dst_o  (merged)
  );

  always_comb begin
    bad_type = pack_kind_e'(type_i) != PK_COLOR;
    bad_mask = mask_kind_e'(mask_i) == MK_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o   <= 1'b0;
      unsupported_o <= 1'b0;
      mask_err_o    <= 1'b0;
      dst_o         <= '0;
    end else begin
      out_valid_o   <= in_valid_i;
      unsupported_o <= in_valid_i & bad_type;
      mask_err_o    <= in_valid_i & bad_mask;
      if (in_valid_i) dst_o <= (bad_type || bad_mask) ? dst_i : merged;
    end
  end
endmodule

module cpi_checker (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic [127:0] dst_i,
  input logic [2:0]   type_i,
  input logic [1:0]   mask_i,
  input logic [1:0]   shift_i,
  input logic         out_valid_o,
  input logic [127:0] dst_o,
  input logic         unsupported_o,
  input logic         mask_err_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R9
  AST_FLAGS_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unsupported_o || mask_err_o) |-> out_valid_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(dst_o)); // R9
  AST_UNSUP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && type_i != 3'd0) |=> (unsupported_o && dst_o == $past(dst_i))); // R1
  AST_MASK_ERR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_i == 2'd0) |=> (mask_err_o && dst_o == $past(dst_i))); // R8
  AST_ONE_WORD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && type_i == 3'd0 && mask_i == 2'd1 && shift_i == 2'd0)
      |=> dst_o[127:32] == $past(dst_i[127:32])); // R5
  AST_ALT_CORNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && type_i == 3'd0 && mask_i == 2'd3 && shift_i == 2'd3)
      |=> (dst_o[31:0] == 32'h0 && dst_o[127:32] == $past(dst_i[127:32]))); // R7
endmodule

bind color_pack_insert cpi_checker i_chk (.*);

// File: tb/test_color_pack_insert.sv
module test_color_pack_insert;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src = '0, dst = '0;
  logic [2:0]   typ = '0;
  logic [1:0]   mask = '0, shift = '0;
  logic         out_valid, unsup, merr;
  logic [127:0] dst_out;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  color_pack_insert i_color_pack_insert (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .src_i(src), .dst_i(dst), .type_i(typ), .mask_i(mask), .shift_i(shift),
    .out_valid_o(out_valid), .dst_o(dst_out),
    .unsupported_o(unsup), .mask_err_o(merr)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] chan_of(input logic [31:0] v);
    longint sv;
    sv = longint'($signed(v));
    if (sv < 64'sh4040_0000) return 8'h00;
    if (sv > 64'sh4040_00FF) return 8'hFF;
    return 8'(sv - 64'sh4040_0000);
  endfunction

  function automatic logic [31:0] pack_of(input logic [127:0] s);
    return {chan_of(s[31:0]), chan_of(s[127:96]), chan_of(s[95:64]), chan_of(s[63:32])};
  endfunction

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] d,
                                         input logic [2:0] t, input logic [1:0] m,
                                         input logic [1:0] sh);
    logic [127:0] r;
    int p;
    r = d;
    if (t != 0 || m == 0) return r;
    if (m == 3 && sh == 3) begin
      r[31:0] = '0;
      return r;
    end
    p = 3 - int'(sh);
    r[(3-p)*32 +: 32] = pack_of(s);
    if (m >= 2 && p >= 1) r[(4-p)*32 +: 32] = '0;
    return r;
  endfunction

  task automatic run_op(input logic [127:0] s, input logic [127:0] d,
                        input logic [2:0] t, input logic [1:0] m, input logic [1:0] sh);
    string tag;
    @(negedge clk);
    src = s; dst = d; typ = t; mask = m; shift = sh; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (t != 0)                tag = "R1";
    else if (m == 0)           tag = "R8";
    else if (m == 3 && sh == 3) tag = "R7";
    else if (m >= 2)           tag = "R6";
    else                       tag = "R5";
    check({tag, " dst R4"}, dst_out, model(s, d, t, m, sh));
    check("R1 unsupported", {127'b0, unsup}, {127'b0, t != 0});
    check("R8 mask_err", {127'b0, merr}, {127'b0, m == 0});
    check("R9 valid", {127'b0, out_valid}, 128'd1);
    @(negedge clk);
    check("R9 pulse end", {127'b0, out_valid}, 128'd0);
    check("R9 hold", dst_out, model(s, d, t, m, sh));
  endtask

  logic [31:0] vals [12];

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vals[0] = 32'h0000_0001; vals[1] = 32'h3FFF_FFFF; vals[2] = 32'h4040_0000;
    vals[3] = 32'h4040_0080; vals[4] = 32'h4040_00FF; vals[5] = 32'h4040_0100;
    vals[6] = 32'h7F80_0000; vals[7] = 32'h8000_0000; vals[8] = 32'hC2F6_0000;
    vals[9] = 32'h4B3B_DF83; vals[10] = 32'h7FC0_0000; vals[11] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    check("R9 reset valid", {127'b0, out_valid}, 128'd0);
    check("R9 reset flags", {126'b0, unsup, merr}, 128'd0);
    check("R9 reset dst", dst_out, 128'd0);
    rst_n = 1'b1;

    // R3 reference order: lanes ending 1..4
    run_op({32'h40400001, 32'h40400002, 32'h40400003, 32'h40400004},
           {4{32'hCDCDCDCD}}, 3'd0, 2'd1, 2'd0);
    check("R3 order", {96'b0, dst_out[31:0]}, {96'b0, 32'h04010203});
    // R2 saturation mix
    run_op({32'h40800000, 32'h40000000, 32'hC2F60000, 32'h4B3BDF83},
           {4{32'hCDCDCDCD}}, 3'd0, 2'd1, 2'd0);
    check("R2 saturate", {96'b0, dst_out[31:0]}, {96'b0, 32'hFFFF0000});

    // R1 R4 R5 R6 R7 R8: full field sweep over two source patterns
    for (int pat = 0; pat < 2; pat++)
      for (int t = 0; t < 8; t++)
        for (int m = 0; m < 4; m++)
          for (int sh = 0; sh < 4; sh++)
            run_op(pat == 0 ? {32'h40400011, 32'h40400022, 32'h40400033, 32'h40400044}
                            : {vals[3], vals[8], vals[6], vals[4]},
                   pat == 0 ? {4{32'hCDCDCDCD}} : 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
                   3'(t), 2'(m), 2'(sh));

    // R2 clamp edges rotated through all lane positions
    for (int i = 0; i < 12; i++) begin
      run_op({vals[i], vals[(i+1)%12], vals[(i+3)%12], vals[(i+7)%12]},
             {4{32'hA5A5A5A5}}, 3'd0, 2'd1, 2'd0);
      check("R2 clamp", {96'b0, dst_out[31:0]},
            {96'b0, pack_of({vals[i], vals[(i+1)%12], vals[(i+3)%12], vals[(i+7)%12]})});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule